// File: doc/BRIEF.md
# System Reset Controller with Last-Cause Record

This block merges every reset request of a small processor subsystem into one active-low system reset and keeps a two-bit record of why the most recent reset happened. Requests come from an external active-low reset pin, from two supply monitors and from an internal watchdog. The supply monitors are modelled as digital flags that are high while the supply is above its threshold. The pin and the supply flags are asynchronous. They put the system into reset at once, and their release passes through a synchronizer and then a fixed hold window.

The watchdog is a 15-bit up-counter that starts only when software enables it. Software restarts it with a clear strobe. A power manager strobe that signals entry to the deepest sleep modes also restarts it. If the counter wraps, the watchdog raises its own reset request. The sleep strobe also produces a one-cycle pulse that tells the radio buffers their contents are gone. The block drives a reset-vector value of zero for the processor.

Software reads the cause field after release. A supply dip of either kind reads as a power-on, the pin has its own code, and a watchdog wrap has its own code.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Each of the four sources drives `sys_rst_n` low. The pin and the supply flags act asynchronously. A watchdog wrap drives `sys_rst_n` low right after the clock edge on which the counter wraps.
- R2: `sys_rst_n` stays low for as long as `vdd_por_ok` or `vdd_bod_ok` is low. It can be released only when both are high.
- R3: When the last asynchronous source goes inactive, `sys_rst_n` rises on the 18th rising clock edge after that change: 2 synchronizer stages, then 16 hold cycles. After a watchdog reset, `sys_rst_n` rises on the 17th edge after the edge where it fell.
- R4: `rst_cause` codes are 2'b00 for a supply reset (power-on or brown-out; the two read alike), 2'b01 for the external pin and 2'b10 for a watchdog wrap. 2'b11 is never produced.
- R5: If several sources are seen during one reset episode, the supply code wins over the pin code, and the pin code wins over the watchdog code.
- R6: During a pin or watchdog reset, `rst_cause` keeps its previous value and changes only on the edge that releases `sys_rst_n`. A supply reset may set it to 2'b00 at any time.
- R7: After any reset the watchdog is disabled, so no watchdog reset occurs until `wdt_enable` is strobed. After the enable strobe is sampled on edge E, the wrap reset occurs on edge E+32768.
- R8: A `wdt_clear` strobe sampled on edge K restarts the count, and the next wrap occurs on edge K+32768.
- R9: A `deep_sleep` strobe sampled on edge S forces the count to zero, and the next wrap occurs on edge S+32768.
- R10: `bufs_lost` is high for exactly one cycle, right after the edge that first samples `deep_sleep` high. A held level gives one pulse, and no pulse is produced while the system reset is active.
- R11: `reset_vector` presents address 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| vdd_por_ok | input | 1 | Power-on monitor flag, high when supply is above threshold |
| vdd_bod_ok | input | 1 | Brown-out monitor flag, high when supply is above threshold |
| wdt_enable | input | 1 | Software strobe that enables the watchdog |
| wdt_clear | input | 1 | Software strobe that restarts the watchdog count |
| deep_sleep | input | 1 | Power-manager strobe: entering one of the two deepest sleep modes |
| sys_rst_n | output | 1 | System reset, active low |
| rst_cause | output | 2 | Cause of the last reset (codes in R4) |
| reset_vector | output | 16 | Processor start address |
| bufs_lost | output | 1 | One-cycle pulse: radio buffer contents are invalid |

## Verification
The bench counts edges exactly across the release window. A synchronizer or hold counter that is one stage short or long would release a cycle early or late. It times the watchdog to its exact wrap edge after an enable, a clear and a sleep strobe. A counter that is too narrow, or that ignores either restart, fires on the wrong edge. Random mixes of pin and supply requests check the cause priority and that a brown-out is coded as a power-on. A watchdog reset is checked to leave the old cause untouched until release and to leave the watchdog disabled afterwards; an encoder that updates early, or an enable that survives reset, shows up there. Sleep strobes held for several cycles or raised during reset check that the buffer pulse comes once and never inside reset.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

  typedef enum logic [1:0] {
    CAUSE_PWR = 2'b00,
    CAUSE_PIN = 2'b01,
    CAUSE_WDT = 2'b10
  } cause_e;

  typedef struct packed {
    logic pwr;
    logic pin;
    logic wdt;
  } src_t;

  // highest-priority source seen during an episode
  function automatic cause_e pick_cause(input src_t s);
    if (s.pwr)      return CAUSE_PWR;
    else if (s.pin) return CAUSE_PIN;
    else if (s.wdt) return CAUSE_WDT;
    else            return CAUSE_PWR;
  endfunction

  // fold the current sources into the episode record
  function automatic src_t fold_seen(input src_t old, input src_t now);
    if (now.pwr) return src_t'{pwr: 1'b1, pin: 1'b0, wdt: 1'b0};
    return old | now;
  endfunction

endpackage

// File: rtl/rcc_async_sync.sv
module rcc_async_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic req_async,
  output logic req_sync
);

  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge req_async) begin
        if (req_async) sh <= '1;
        else           sh <= '0;
      end
    end else begin : g_chain
      always_ff @(posedge clk or posedge req_async) begin
        if (req_async) sh <= '1;
        else           sh <= {sh[STAGES-2:0], 1'b0};
      end
    end
  endgenerate

  assign req_sync = sh[STAGES-1];

  AST_SYNC_SETS_AT_ONCE: assert property (@(posedge clk)
    req_async |-> req_sync); // R1

endmodule

// File: rtl/rcc_rst_stretch.sv
module rcc_rst_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic chk_rst,
  input  logic req_any,
  output logic rst_active,
  output logic release_ev
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);
  localparam logic [CW-1:0] LAST_V = CW'(HOLD - 1);

  logic [CW-1:0] hold_cnt;
  logic          hold_done;

  always_ff @(posedge clk) begin
    if (req_any)         hold_cnt <= '0;
    else if (!hold_done) hold_cnt <= hold_cnt + 1'b1;
  end

  assign hold_done  = (hold_cnt == HOLD_V);
  assign rst_active = req_any | ~hold_done;
  assign release_ev = ~req_any & (hold_cnt == LAST_V);

  AST_REQ_FORCES_RST: assert property (@(posedge clk) disable iff (chk_rst)
    req_any |-> rst_active); // R1
  AST_HOLD_AFTER_DROP: assert property (@(posedge clk) disable iff (chk_rst)
    $fell(req_any) |=> rst_active); // R3
  AST_RELEASE_ENDS_RST: assert property (@(posedge clk) disable iff (chk_rst)
    release_ev |=> (!rst_active || req_any)); // R3

endmodule

// File: rtl/rcc_watchdog.sv
module rcc_watchdog #(
  parameter int BITS = 15
) (
  input  logic clk,
  input  logic chk_rst,
  input  logic sys_clr,
  input  logic en_set,
  input  logic kick,
  input  logic sleep_clr,
  output logic fire
);

  logic            wdt_en;
  logic [BITS-1:0] wdt_cnt;
  logic [BITS-1:0] cnt_inc;
  logic            wrap;

  // {carry, next count}
  function automatic logic [BITS:0] step(input logic [BITS-1:0] c);
    return {1'b0, c} + {{BITS{1'b0}}, 1'b1};
  endfunction

  assign {wrap, cnt_inc} = step(wdt_cnt);

  always_ff @(posedge clk) begin
    if (sys_clr) begin
      wdt_en  <= 1'b0;
      wdt_cnt <= '0;
      fire    <= 1'b0;
    end else begin
      wdt_en <= wdt_en | en_set;
      if (sleep_clr || kick || !wdt_en) begin
        wdt_cnt <= '0;
        fire    <= 1'b0;
      end else begin
        wdt_cnt <= cnt_inc;
        fire    <= wrap;
      end
    end
  end

  AST_WDT_OFF_AFTER_RST: assert property (@(posedge clk) disable iff (chk_rst)
    sys_clr |=> !wdt_en); // R7
  AST_FIRE_NEEDS_EN: assert property (@(posedge clk) disable iff (chk_rst)
    fire |-> $past(wdt_en)); // R7
  AST_FIRE_AFTER_FULL: assert property (@(posedge clk) disable iff (chk_rst)
    fire |-> ($past(wdt_cnt) == {BITS{1'b1}})); // R7
  AST_KICK_ZEROES: assert property (@(posedge clk) disable iff (chk_rst)
    kick |=> (wdt_cnt == '0)); // R8
  AST_SLEEP_ZEROES: assert property (@(posedge clk) disable iff (chk_rst)
    sleep_clr |=> (wdt_cnt == '0)); // R9

endmodule

// File: rtl/rcc_cause_rec.sv
module rcc_cause_rec
  import rcc_pkg::*;
(
  input  logic   clk,
  input  logic   chk_rst,
  input  logic   rst_active,
  input  logic   release_ev,
  input  src_t   now,
  output cause_e cause
);

  src_t seen;

  always_ff @(posedge clk) begin
    if (now.pwr) begin
      seen  <= fold_seen(seen, now);
      cause <= CAUSE_PWR;
    end else if (release_ev) begin
      cause <= pick_cause(seen);
      seen  <= '0;
    end else if (rst_active) begin
      seen  <= fold_seen(seen, now);
    end
  end

  AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (chk_rst)
    (!release_ev && !now.pwr) |=> $stable(cause)); // R6
  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (chk_rst)
    $past(release_ev) |-> (cause != 2'b11)); // R4
  AST_PWR_WINS: assert property (@(posedge clk) disable iff (chk_rst)
    (release_ev && seen.pwr) |=> (cause == CAUSE_PWR)); // R5

endmodule

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl
  import rcc_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          HOLD_CYC    = 16,
  parameter int          WDT_BITS    = 15,
  parameter int          VEC_W       = 16,
  parameter logic [15:0] RESET_ADDR  = 16'h0000
) (
  input  logic             clk,
  input  logic             ext_rst_n,
  input  logic             vdd_por_ok,
  input  logic             vdd_bod_ok,
  input  logic             wdt_enable,
  input  logic             wdt_clear,
  input  logic             deep_sleep,
  output logic             sys_rst_n,
  output logic [1:0]       rst_cause,
  output logic [VEC_W-1:0] reset_vector,
  output logic             bufs_lost
);

  localparam int NASYNC = 3;
  localparam int IDX_PIN = 0;
  localparam int IDX_POR = 1;
  localparam int IDX_BOD = 2;

  logic [NASYNC-1:0] raw_req;
  logic [NASYNC-1:0] sync_req;
  logic              wdt_fire;
  logic              req_any;
  logic              rst_active;
  logic              release_ev;
  logic              chk_rst;
  logic              sleep_q;
  src_t              now_src;
  cause_e            cause_q;

  assign raw_req[IDX_PIN] = ~ext_rst_n;
  assign raw_req[IDX_POR] = ~vdd_por_ok;
  assign raw_req[IDX_BOD] = ~vdd_bod_ok;
  assign chk_rst          = raw_req[IDX_POR] | raw_req[IDX_BOD];

  generate
    for (genvar i = 0; i < NASYNC; i++) begin : g_sync
      rcc_async_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .req_async (raw_req[i]),
        .req_sync  (sync_req[i])
      );
    end
  endgenerate

  assign now_src.pwr = sync_req[IDX_POR] | sync_req[IDX_BOD];
  assign now_src.pin = sync_req[IDX_PIN];
  assign now_src.wdt = wdt_fire;
  assign req_any     = |sync_req | wdt_fire;

  rcc_rst_stretch #(.HOLD(HOLD_CYC)) u_stretch (
    .clk        (clk),
    .chk_rst    (chk_rst),
    .req_any    (req_any),
    .rst_active (rst_active),
    .release_ev (release_ev)
  );

  rcc_watchdog #(.BITS(WDT_BITS)) u_wdt (
    .clk       (clk),
    .chk_rst   (chk_rst),
    .sys_clr   (rst_active),
    .en_set    (wdt_enable),
    .kick      (wdt_clear),
    .sleep_clr (deep_sleep),
    .fire      (wdt_fire)
  );

  rcc_cause_rec u_cause (
    .clk        (clk),
    .chk_rst    (chk_rst),
    .rst_active (rst_active),
    .release_ev (release_ev),
    .now        (now_src),
    .cause      (cause_q)
  );

  always_ff @(posedge clk) begin
    sleep_q   <= deep_sleep;
    bufs_lost <= deep_sleep & ~sleep_q & ~rst_active;
  end

  assign sys_rst_n    = ~rst_active;
  assign rst_cause    = cause_q;
  assign reset_vector = VEC_W'(RESET_ADDR);

  AST_SUPPLY_LOW_HOLDS: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (!vdd_por_ok || !vdd_bod_ok) |-> !sys_rst_n); // R2
  AST_BUF_SINGLE: assert property (@(posedge clk) disable iff (chk_rst)
    bufs_lost |=> !bufs_lost); // R10
  AST_BUF_NOT_IN_RST: assert property (@(posedge clk) disable iff (chk_rst)
    rst_active |=> !bufs_lost); // R10

endmodule

// File: tb/tb_rst_cause_ctrl.sv
module tb_rst_cause_ctrl;

  localparam int REL_ASYNC = 18;     // 2 sync + 16 hold
  localparam int REL_WDT   = 17;     // 1 clear + 16 hold
  localparam int WDT_BITS  = 15;

  logic        clk = 1'b0;
  logic        ext_rst_n = 1'b1, vdd_por_ok = 1'b1, vdd_bod_ok = 1'b1;
  logic        wdt_enable = 1'b0, wdt_clear = 1'b0, deep_sleep = 1'b0;
  logic        sys_rst_n;
  logic [1:0]  rst_cause;
  logic [15:0] reset_vector;
  logic        bufs_lost;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rst_cause_ctrl dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .vdd_por_ok(vdd_por_ok),
    .vdd_bod_ok(vdd_bod_ok), .wdt_enable(wdt_enable), .wdt_clear(wdt_clear),
    .deep_sleep(deep_sleep), .sys_rst_n(sys_rst_n), .rst_cause(rst_cause),
    .reset_vector(reset_vector), .bufs_lost(bufs_lost)
  );

  function automatic logic [1:0] exp_cause(input bit pwr, input bit pin, input bit wdt);
    if (pwr) return 2'b00;
    if (pin) return 2'b01;
    if (wdt) return 2'b10;
    return 2'b00;
  endfunction

  function automatic int wdt_period(input int bits);
    return 1 << bits;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // raise every async source at a negedge, then time the release
  task automatic drop_all(input string tag, input logic [1:0] cause_exp);
    @(negedge clk);
    ext_rst_n = 1'b1; vdd_por_ok = 1'b1; vdd_bod_ok = 1'b1;
    edges(REL_ASYNC - 1);
    chk({tag, " R3 still low"}, sys_rst_n, 1'b0);
    edges(1);
    chk({tag, " R3 released"}, sys_rst_n, 1'b1);
    chk({tag, " R4 cause"}, rst_cause, cause_exp);
  endtask

  task automatic strobe_en();
    @(negedge clk); wdt_enable = 1'b1; @(posedge clk); #1 wdt_enable = 1'b0;
  endtask
  task automatic strobe_clr();
    @(negedge clk); wdt_clear = 1'b1; @(posedge clk); #1 wdt_clear = 1'b0;
  endtask
  task automatic strobe_sleep();
    @(negedge clk); deep_sleep = 1'b1; @(posedge clk); #1 deep_sleep = 1'b0;
  endtask

  // after strobe edge: wrap edge is at +period; then released 17 edges later
  task automatic expect_wrap(input string tag, input int already);
    edges(wdt_period(WDT_BITS) - 1 - already);
    chk({tag, " no reset before wrap"}, sys_rst_n, 1'b1);
    edges(1);
    chk({tag, " reset on wrap"}, sys_rst_n, 1'b0);
  endtask

  task automatic wdt_release(input string tag);
    edges(REL_WDT - 1);
    chk({tag, " R3 wdt still low"}, sys_rst_n, 1'b0);
    edges(1);
    chk({tag, " R3 wdt released"}, sys_rst_n, 1'b1);
    chk({tag, " R4 cause watchdog"}, rst_cause, 2'b10);
  endtask

  initial begin : watchdog_timer
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin : main
    logic [1:0] prev;
    void'($urandom(32'd20240611));

    // power-up: both supply flags low before the first edge
    #1 vdd_por_ok = 1'b0; vdd_bod_ok = 1'b0;
    #1 chk("R2 reset at power-up", sys_rst_n, 1'b0);
    chk("R11 vector", reset_vector, 16'h0000);
    edges(5);
    @(negedge clk) vdd_por_ok = 1'b1;
    edges(30);
    chk("R2 held by brown-out flag", sys_rst_n, 1'b0);
    drop_all("R2 power-up", 2'b00);
    chk("R11 vector after reset", reset_vector, 16'h0000);

    // brown-out alone reads as power-on
    @(negedge clk) vdd_bod_ok = 1'b0;
    #1 chk("R1 brown-out asserts", sys_rst_n, 1'b0);
    edges(5);
    drop_all("R4 brown-out code", 2'b00);

    // pin reset, with sleep strobes inside reset (no pulse)
    @(negedge clk) ext_rst_n = 1'b0;
    #1 chk("R1 pin asserts async", sys_rst_n, 1'b0);
    @(negedge clk) deep_sleep = 1'b1;
    edges(1); chk("R10 no pulse in reset", bufs_lost, 1'b0);
    edges(1); chk("R10 no pulse in reset 2", bufs_lost, 1'b0);
    @(negedge clk) deep_sleep = 1'b0;
    chk("R6 cause held in pin reset", rst_cause, 2'b00);
    drop_all("R1 pin", 2'b01);

    // held sleep level gives one pulse
    @(negedge clk) deep_sleep = 1'b1;
    edges(1); chk("R10 pulse", bufs_lost, 1'b1);
    edges(1); chk("R10 single pulse", bufs_lost, 1'b0);
    edges(2); chk("R10 held level no repeat", bufs_lost, 1'b0);
    @(negedge clk) deep_sleep = 1'b0;

    // pin and supply together: supply wins
    @(negedge clk) ext_rst_n = 1'b0;
    edges(3);
    @(negedge clk) vdd_por_ok = 1'b0;
    edges(3);
    @(negedge clk) vdd_por_ok = 1'b1;
    edges(4);
    drop_all("R5 supply over pin", 2'b00);

    // pin last so the watchdog test sees cause 01 beforehand
    @(negedge clk) ext_rst_n = 1'b0;
    edges(2);
    drop_all("R4 pin code", 2'b01);

    // disabled watchdog never fires
    edges(wdt_period(WDT_BITS) + 100);
    chk("R7 disabled after reset", sys_rst_n, 1'b1);

    // enabled watchdog wraps at exactly 2^15
    strobe_en();
    expect_wrap("R7 timeout", 0);
    chk("R6 cause kept during wdt reset", rst_cause, 2'b01);
    wdt_release("R7");

    // after the watchdog reset it is off again
    for (int k = 0; k < 34; k++) begin
      edges(1000);
      if (k % 11 == 0) chk("R7 stays disabled", sys_rst_n, 1'b1);
    end

    // clear and sleep restart the count
    strobe_en();
    edges(30000);
    strobe_clr();
    edges(30000);
    chk("R8 clear prevented wrap", sys_rst_n, 1'b1);
    strobe_sleep();
    chk("R10 sleep pulse", bufs_lost, 1'b1);
    edges(1);
    chk("R10 sleep pulse ends", bufs_lost, 1'b0);
    expect_wrap("R9 sleep restart", 1);
    wdt_release("R9");

    // random mixes of async sources
    prev = rst_cause;
    for (int it = 0; it < 14; it++) begin
      int mask;
      int hold;
      bit pwr;
      mask = $urandom_range(1, 7);
      hold = $urandom_range(1, 12);
      pwr  = (mask[1] | mask[2]);
      @(negedge clk);
      ext_rst_n  = ~mask[0];
      vdd_por_ok = ~mask[1];
      vdd_bod_ok = ~mask[2];
      #1 chk("R1 random assert", sys_rst_n, 1'b0);
      edges(hold);
      if (!pwr) chk("R6 random cause held", rst_cause, prev);
      drop_all("R5 random", exp_cause(pwr, mask[0], 1'b0));
      prev = rst_cause;
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule